// File: doc/BRIEF.md
# Serial Transmitter with Buffer-Empty and Done Flags

This block sends characters on a single serial line. A one-character holding register sits in front of a shift register, so software can place the next character while the current one is still going out. Two sticky status flags report the state of the path: a buffer-empty flag and a transmission-done flag. Baud timing comes from outside as a one-cycle `bit_tick` pulse per bit time. Apart from data characters, the transmitter can send a preamble, which is one frame time of continuous 1s, and a break, which is one frame time of continuous 0s.

The flags are not cleared by writing to them. A flag is cleared in two steps. First, a status read (`stat_rd`) sees the flag at 1; this arms the flag. Second, a qualifying action follows with no other register access in between. For the buffer-empty flag, the qualifying action is a data write. For the done flag, it is a data write, a control write that turns the enable on from off, or a control write with the break bit set. A data write that was not armed still loads the holding register, but it leaves both flags unchanged.

A four-state machine drives the line. The states are `TX_IDLE`, `TX_DATA`, `TX_PREAMBLE` and `TX_BREAK`. On a bit tick, `TX_IDLE` moves to one of the three busy states (launch). On the tick that ends a frame, a busy state either launches the next item directly, without an idle gap, or returns to `TX_IDLE` (frame end). Launch picks work in this order: preamble first, then break, then buffered data. No launch happens while the enable is off.

Top module: `serial_tx_flags`

## Requirements
- R1: After reset, `txd` is 1 and both `buf_empty` and `tx_done` are 1.
- R2: A data frame starts with a 0 start bit, continues with the data bits LSB first and ends with a 1 stop bit. With `ctrl_long`=0 the frame carries 8 data bits (`data_in[7:0]`) and lasts 10 bit times. With `ctrl_long`=1 it carries 9 bits and lasts 11 bit times. The frame length is the `ctrl_long` value in force when the frame launches.
- R3: `buf_empty` becomes 1 in the clock cycle after a buffered character moves into the shifter. The move happens on a `bit_tick` while the transmitter is idle or finishing a frame.
- R4: `buf_empty` falls only on a data write that follows a status read which saw `buf_empty`=1, with no other register access in between.
- R5: `tx_done` becomes 1 two cycles after the tick that ends the last frame, provided nothing is buffered and no preamble or break is queued.
- R6: After a status read that saw `tx_done`=1, any one of these actions clears `tx_done`: a data write, a control write that turns `ctrl_en` on from 0, or a control write with `ctrl_brk`=1.
- R7: A control write that turns the enable on from 0 queues a preamble: one frame time (10 or 11 bit times) of 1 on `txd`.
- R8: A control write with `ctrl_brk`=1 queues a break: one frame time of 0 on `txd`, followed by the line returning to 1.
- R9: A data write that is not armed loads the character and sends it, but leaves both flags unchanged. Any data or control write between the status read and the action disarms the pending clear.
- R10: While the enable is 0, `txd` stays 1 and nothing launches. Once the enable is on, queued work goes out in this order: preamble, then break, then data.
- R11: `txd` changes only in the cycle after a `bit_tick`. Each bit lasts one tick interval. A character that is ready when a frame ends starts on that same tick, with no idle bit in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| data_wr | input | 1 | Data register write strobe |
| data_in | input | DATA_W | Character to send |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_en | input | 1 | Transmit enable value written |
| ctrl_brk | input | 1 | 1 queues a break character |
| ctrl_long | input | 1 | 1 selects the 11-bit frame, 0 the 10-bit frame |
| stat_rd | input | 1 | Status register read strobe |
| txd | output | 1 | Serial line, idles high |
| buf_empty | output | 1 | Holding register empty flag |
| tx_done | output | 1 | Transmission complete flag |

## Verification
The bench builds the block with the default `DATA_W`=9, so both the 10-bit and the 11-bit frame lengths are reachable and the ninth data bit is exercised in long mode. It generates `bit_tick` every 8 clocks. Each bit interval therefore has enough cycles for a status read and a write to land before the launch tick, and for the one-cycle dip of `buf_empty` between an armed write and the launch to be observed. The short tick period also keeps the back-to-back and preamble/break/data ordering cases within a few hundred cycles.

// File: rtl/serial_tx_flags_pkg.sv
package serial_tx_flags_pkg;

    typedef enum logic [1:0] {
        TX_IDLE,
        TX_DATA,
        TX_PREAMBLE,
        TX_BREAK
    } tx_state_e;

    typedef enum logic [1:0] {
        PICK_NONE,
        PICK_DATA,
        PICK_PRE,
        PICK_BRK
    } tx_pick_e;

    // Priority among queued work: preamble, then break, then buffered data.
    function automatic tx_pick_e choose_work(input logic en, input logic pre,
                                             input logic brk, input logic full);
        if (!en)       return PICK_NONE;
        else if (pre)  return PICK_PRE;
        else if (brk)  return PICK_BRK;
        else if (full) return PICK_DATA;
        else           return PICK_NONE;
    endfunction

endpackage

// File: rtl/txs_ctrl_regs.sv
module txs_ctrl_regs #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ctrl_wr,
    input  logic              ctrl_en,
    input  logic              ctrl_brk,
    input  logic              ctrl_long,
    input  logic              take_buf,
    input  logic              take_pre,
    input  logic              take_brk,
    output logic              tx_en,
    output logic              long_mode,
    output logic [DATA_W-1:0] hold_data,
    output logic              hold_full,
    output logic              pre_pend,
    output logic              brk_pend,
    output logic              en_rise,
    output logic              brk_req
);

    assign en_rise = ctrl_wr && ctrl_en && !tx_en;
    assign brk_req = ctrl_wr && ctrl_brk;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_en     <= 1'b0;
            long_mode <= 1'b0;
        end else if (ctrl_wr) begin
            tx_en     <= ctrl_en;
            long_mode <= ctrl_long;
        end
    end

    // A new write wins over a same-cycle transfer: the old value moves out,
    // the new one stays buffered.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_data <= '0;
            hold_full <= 1'b0;
        end else if (data_wr) begin
            hold_data <= data_in;
            hold_full <= 1'b1;
        end else if (take_buf) begin
            hold_full <= 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_pend <= 1'b0;
            brk_pend <= 1'b0;
        end else begin
            if (en_rise)       pre_pend <= 1'b1;
            else if (take_pre) pre_pend <= 1'b0;
            if (brk_req)       brk_pend <= 1'b1;
            else if (take_brk) brk_pend <= 1'b0;
        end
    end

endmodule

// File: rtl/txs_flag_unit.sv
module txs_flag_unit (
    input  logic clk,
    input  logic rst_n,
    input  logic stat_rd,
    input  logic data_wr,
    input  logic ctrl_wr,
    input  logic en_rise,
    input  logic brk_req,
    input  logic take_buf,
    input  logic line_quiet,
    output logic buf_empty,
    output logic tx_done,
    output logic arm_empty,
    output logic arm_done
);

    logic clr_empty;
    logic clr_done;

    assign clr_empty = data_wr && arm_empty;
    assign clr_done  = arm_done && (data_wr || (ctrl_wr && (en_rise || brk_req)));

    // Arming: a status read captures which flags it saw at 1; any write
    // afterwards consumes or discards that capture.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            arm_empty <= 1'b0;
            arm_done  <= 1'b0;
        end else if (stat_rd) begin
            arm_empty <= buf_empty;
            arm_done  <= tx_done;
        end else if (data_wr || ctrl_wr) begin
            arm_empty <= 1'b0;
            arm_done  <= 1'b0;
        end
    end

    // Clearing takes priority over setting in both flags.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            buf_empty <= 1'b1;
            tx_done   <= 1'b1;
        end else begin
            if (clr_empty)     buf_empty <= 1'b0;
            else if (take_buf) buf_empty <= 1'b1;
            if (clr_done)        tx_done <= 1'b0;
            else if (line_quiet) tx_done <= 1'b1;
        end
    end

endmodule

// File: rtl/txs_frame_fsm.sv
module txs_frame_fsm
    import serial_tx_flags_pkg::*;
#(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              tx_en,
    input  logic              long_mode,
    input  logic [DATA_W-1:0] hold_data,
    input  logic              hold_full,
    input  logic              pre_pend,
    input  logic              brk_pend,
    output logic              txd,
    output logic              take_buf,
    output logic              take_pre,
    output logic              take_brk,
    output logic              busy
);

    localparam int SH_W     = DATA_W + 2;
    localparam int FL_SHORT = DATA_W + 1;
    localparam int FL_LONG  = DATA_W + 2;
    localparam int CNT_W    = $clog2(FL_LONG);

    tx_state_e        state_q, state_d;
    tx_pick_e         pick;
    logic [SH_W-1:0]  shreg_q;
    logic [CNT_W-1:0] bit_cnt_q;
    logic             frame_long_q;
    logic [CNT_W-1:0] last_idx;
    logic             frame_end;
    logic             launch_slot;
    logic             launch;
    logic [SH_W-1:0]  load_val;

    assign pick        = choose_work(tx_en, pre_pend, brk_pend, hold_full);
    assign busy        = (state_q != TX_IDLE);
    assign last_idx    = frame_long_q ? CNT_W'(FL_LONG - 1) : CNT_W'(FL_SHORT - 1);
    assign frame_end   = busy && bit_tick && (bit_cnt_q == last_idx);
    assign launch_slot = bit_tick && (!busy || frame_end);
    assign launch      = launch_slot && (pick != PICK_NONE);

    assign take_buf = launch && (pick == PICK_DATA);
    assign take_pre = launch && (pick == PICK_PRE);
    assign take_brk = launch && (pick == PICK_BRK);

    // Frame image, bit 0 first: start, data LSB first, optional ninth bit, stop.
    always_comb begin
        load_val                  = '1;
        load_val[0]               = 1'b0;
        load_val[DATA_W-1:1]      = hold_data[DATA_W-2:0];
        load_val[DATA_W]          = long_mode ? hold_data[DATA_W-1] : 1'b1;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE: begin
                if (launch) begin
                    unique case (pick)
                        PICK_DATA: state_d = TX_DATA;
                        PICK_PRE:  state_d = TX_PREAMBLE;
                        PICK_BRK:  state_d = TX_BREAK;
                        PICK_NONE: state_d = TX_IDLE;
                    endcase
                end
            end
            TX_DATA, TX_PREAMBLE, TX_BREAK: begin
                if (frame_end) begin
                    unique case (pick)
                        PICK_DATA: state_d = TX_DATA;
                        PICK_PRE:  state_d = TX_PREAMBLE;
                        PICK_BRK:  state_d = TX_BREAK;
                        PICK_NONE: state_d = TX_IDLE;
                    endcase
                end
            end
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= TX_IDLE;
        else        state_q <= state_d;
    end

    // Datapath registers: shifter, bit counter, latched frame length.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg_q      <= '1;
            bit_cnt_q    <= '0;
            frame_long_q <= 1'b0;
        end else if (launch) begin
            shreg_q      <= load_val;
            bit_cnt_q    <= '0;
            frame_long_q <= long_mode;
        end else if (busy && bit_tick) begin
            shreg_q      <= {1'b1, shreg_q[SH_W-1:1]};
            bit_cnt_q    <= bit_cnt_q + 1'b1;
        end
    end

    // Outputs.
    always_comb begin
        unique case (state_q)
            TX_IDLE:     txd = 1'b1;
            TX_DATA:     txd = shreg_q[0];
            TX_PREAMBLE: txd = 1'b1;
            TX_BREAK:    txd = 1'b0;
        endcase
    end

endmodule

// File: rtl/serial_tx_flags.sv
module serial_tx_flags #(
    parameter int DATA_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_tick,
    input  logic              data_wr,
    input  logic [DATA_W-1:0] data_in,
    input  logic              ctrl_wr,
    input  logic              ctrl_en,
    input  logic              ctrl_brk,
    input  logic              ctrl_long,
    input  logic              stat_rd,
    output logic              txd,
    output logic              buf_empty,
    output logic              tx_done
);

    logic              tx_en;
    logic              long_mode;
    logic [DATA_W-1:0] hold_data;
    logic              hold_full;
    logic              pre_pend;
    logic              brk_pend;
    logic              en_rise;
    logic              brk_req;
    logic              take_buf;
    logic              take_pre;
    logic              take_brk;
    logic              busy;
    logic              line_quiet;
    logic              arm_empty;
    logic              arm_done;

    assign line_quiet = !busy && !hold_full && !pre_pend && !brk_pend;

    txs_ctrl_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_wr   (data_wr),
        .data_in   (data_in),
        .ctrl_wr   (ctrl_wr),
        .ctrl_en   (ctrl_en),
        .ctrl_brk  (ctrl_brk),
        .ctrl_long (ctrl_long),
        .take_buf  (take_buf),
        .take_pre  (take_pre),
        .take_brk  (take_brk),
        .tx_en     (tx_en),
        .long_mode (long_mode),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .pre_pend  (pre_pend),
        .brk_pend  (brk_pend),
        .en_rise   (en_rise),
        .brk_req   (brk_req)
    );

    txs_frame_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .tx_en     (tx_en),
        .long_mode (long_mode),
        .hold_data (hold_data),
        .hold_full (hold_full),
        .pre_pend  (pre_pend),
        .brk_pend  (brk_pend),
        .txd       (txd),
        .take_buf  (take_buf),
        .take_pre  (take_pre),
        .take_brk  (take_brk),
        .busy      (busy)
    );

    txs_flag_unit u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .stat_rd    (stat_rd),
        .data_wr    (data_wr),
        .ctrl_wr    (ctrl_wr),
        .en_rise    (en_rise),
        .brk_req    (brk_req),
        .take_buf   (take_buf),
        .line_quiet (line_quiet),
        .buf_empty  (buf_empty),
        .tx_done    (tx_done),
        .arm_empty  (arm_empty),
        .arm_done   (arm_done)
    );

endmodule

// File: rtl/serial_tx_flags_chk.sv
module serial_tx_flags_chk (
    input logic clk,
    input logic rst_n,
    input logic bit_tick,
    input logic data_wr,
    input logic ctrl_wr,
    input logic txd,
    input logic buf_empty,
    input logic tx_done,
    input logic take_buf,
    input logic arm_empty,
    input logic tx_en,
    input logic busy
);

    // R4: the empty flag never falls without a data write in the cycle before.
    p_empty_needs_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !data_wr |=> !$fell(buf_empty));

    // R6: the done flag never falls without a data or control write.
    p_done_needs_access_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(data_wr || ctrl_wr) |=> !$fell(tx_done));

    // R9: an unarmed data write leaves a set empty flag set.
    p_unarmed_keeps_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (data_wr && !arm_empty && buf_empty) |=> buf_empty);

    // R3: the empty flag rises only after a transfer into the shifter.
    p_empty_rise_on_take_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !take_buf |=> !$rose(buf_empty));

    // R11: the line moves only right after a bit tick.
    p_line_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_tick |=> $stable(txd));

    // R5: done rises only with the line at the idle level.
    p_done_line_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_done) |-> txd);

    // R10: idle and disabled keeps the line high next cycle.
    p_disabled_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en && !busy) |=> txd);

endmodule

bind serial_tx_flags serial_tx_flags_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_tick  (bit_tick),
    .data_wr   (data_wr),
    .ctrl_wr   (ctrl_wr),
    .txd       (txd),
    .buf_empty (buf_empty),
    .tx_done   (tx_done),
    .take_buf  (take_buf),
    .arm_empty (arm_empty),
    .tx_en     (tx_en),
    .busy      (busy)
);

// File: tb/serial_tx_flags_bench.sv
module serial_tx_flags_bench;

    localparam int CLK_PERIOD = 10;
    localparam int TICK_DIV   = 8;
    localparam int DATA_W     = 9;
    localparam int LOG_D      = 4096;
    localparam int MID        = TICK_DIV / 2;
    localparam int SLOT       = MID + 1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bit_tick = 1'b0;
    logic              data_wr = 1'b0;
    logic [DATA_W-1:0] data_in = '0;
    logic              ctrl_wr = 1'b0;
    logic              ctrl_en = 1'b0;
    logic              ctrl_brk = 1'b0;
    logic              ctrl_long = 1'b0;
    logic              stat_rd = 1'b0;
    logic              txd;
    logic              buf_empty;
    logic              tx_done;

    int   tick_cnt = 0;
    logic line_log  [LOG_D];
    logic empty_log [LOG_D];
    logic done_log  [LOG_D];
    int   log_n = 0;
    int   n_chk = 0;
    int   n_bad = 0;

    serial_tx_flags #(.DATA_W(DATA_W)) u_serial_tx_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_tick  (bit_tick),
        .data_wr   (data_wr),
        .data_in   (data_in),
        .ctrl_wr   (ctrl_wr),
        .ctrl_en   (ctrl_en),
        .ctrl_brk  (ctrl_brk),
        .ctrl_long (ctrl_long),
        .stat_rd   (stat_rd),
        .txd       (txd),
        .buf_empty (buf_empty),
        .tx_done   (tx_done)
    );

    initial forever #(CLK_PERIOD / 2) clk = ~clk;

    // Bit tick generator: one pulse every TICK_DIV clocks.
    initial forever begin
        @(posedge clk);
        bit_tick <= (tick_cnt == TICK_DIV - 2);
        tick_cnt <= (tick_cnt == TICK_DIV - 1) ? 0 : tick_cnt + 1;
    end

    // Line monitor: one sample per bit interval, in its middle.
    initial forever begin
        @(negedge clk);
        if (tick_cnt == MID && log_n < LOG_D) begin
            line_log[log_n]  = txd;
            empty_log[log_n] = buf_empty;
            done_log[log_n]  = tx_done;
            log_n++;
        end
    end

    function automatic int frame_len(input logic lng);
        return lng ? DATA_W + 2 : DATA_W + 1;
    endfunction

    function automatic logic [15:0] exp_frame(input logic [DATA_W-1:0] d, input logic lng);
        logic [15:0] f;
        f = '0;
        f[0] = 1'b0;
        for (int i = 0; i < 8; i++) f[i+1] = d[i];
        if (lng) begin
            f[9]  = d[8];
            f[10] = 1'b1;
        end else begin
            f[9] = 1'b1;
        end
        return f;
    endfunction

    function automatic logic [15:0] fill_frame(input logic v, input int fl);
        logic [15:0] f;
        f = '0;
        for (int i = 0; i < fl; i++) f[i] = v;
        return f;
    endfunction

    function automatic logic [15:0] got_frame(input int n0, input int fl);
        logic [15:0] g;
        g = '0;
        for (int i = 0; i < fl; i++) g[i] = line_log[n0 + i];
        return g;
    endfunction

    task automatic check(input logic ok, input string req, input string what,
                         input logic [31:0] got, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
        end
    endtask

    task automatic align();
        do @(negedge clk); while (tick_cnt != SLOT);
    endtask

    task automatic wait_bits(input int n);
        repeat (n * TICK_DIV) @(negedge clk);
    endtask

    task automatic do_read();
        stat_rd = 1'b1;
        @(negedge clk);
        stat_rd = 1'b0;
    endtask

    task automatic do_data(input logic [DATA_W-1:0] d);
        data_in = d;
        data_wr = 1'b1;
        @(negedge clk);
        data_wr = 1'b0;
    endtask

    task automatic do_ctrl(input logic en, input logic brk, input logic lng);
        ctrl_en   = en;
        ctrl_brk  = brk;
        ctrl_long = lng;
        ctrl_wr   = 1'b1;
        @(negedge clk);
        ctrl_wr   = 1'b0;
        ctrl_brk  = 1'b0;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int n0;
        logic [DATA_W-1:0] a, b;
        void'($urandom(32'h0000_5EED));

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(txd == 1'b1, "R1", "reset line", txd, 1);
        check(buf_empty == 1'b1, "R1", "reset empty flag", buf_empty, 1);
        check(tx_done == 1'b1, "R1", "reset done flag", tx_done, 1);

        // R7 / R6: armed enable turns on a preamble and clears done.
        align();
        do_read();
        n0 = log_n;
        do_ctrl(1'b1, 1'b0, 1'b0);
        check(tx_done == 1'b0, "R6", "done after armed enable", tx_done, 0);
        wait_bits(12);
        check(got_frame(n0, 10) == fill_frame(1'b1, 10), "R7", "preamble bits",
              got_frame(n0, 10), fill_frame(1'b1, 10));
        check(done_log[n0 + 9] == 1'b0, "R5", "done during preamble", done_log[n0 + 9], 0);
        check(done_log[n0 + 10] == 1'b1, "R5", "done after preamble", done_log[n0 + 10], 1);

        // R8: break queued by an armed control write.
        align();
        do_read();
        n0 = log_n;
        do_ctrl(1'b1, 1'b1, 1'b0);
        check(tx_done == 1'b0, "R6", "done after armed break", tx_done, 0);
        wait_bits(12);
        check(got_frame(n0, 10) == fill_frame(1'b0, 10), "R8", "break bits",
              got_frame(n0, 10), fill_frame(1'b0, 10));
        check(line_log[n0 + 10] == 1'b1, "R8", "line after break", line_log[n0 + 10], 1);
        check(done_log[n0 + 10] == 1'b1, "R5", "done after break", done_log[n0 + 10], 1);

        // R2 / R3 / R4: armed short data frame.
        align();
        do_read();
        n0 = log_n;
        do_data(9'h0A5);
        check(buf_empty == 1'b0, "R4", "empty after armed write", buf_empty, 0);
        check(tx_done == 1'b0, "R6", "done after armed write", tx_done, 0);
        wait_bits(12);
        check(got_frame(n0, 10) == exp_frame(9'h0A5, 1'b0), "R2", "short frame",
              got_frame(n0, 10), exp_frame(9'h0A5, 1'b0));
        check(empty_log[n0] == 1'b1, "R3", "empty after transfer", empty_log[n0], 1);
        check(done_log[n0 + 9] == 1'b0, "R5", "done mid frame", done_log[n0 + 9], 0);
        check(done_log[n0 + 10] == 1'b1, "R5", "done after frame", done_log[n0 + 10], 1);

        // R9: unarmed write sends but leaves flags.
        align();
        n0 = log_n;
        do_data(9'h13C);
        check(buf_empty == 1'b1, "R9", "empty after unarmed write", buf_empty, 1);
        check(tx_done == 1'b1, "R9", "done after unarmed write", tx_done, 1);
        wait_bits(12);
        check(got_frame(n0, 10) == exp_frame(9'h13C, 1'b0), "R9", "unarmed frame",
              got_frame(n0, 10), exp_frame(9'h13C, 1'b0));

        // R9: control write between read and data write disarms.
        align();
        do_read();
        do_ctrl(1'b1, 1'b0, 1'b0);
        n0 = log_n;
        do_data(9'h066);
        check(buf_empty == 1'b1, "R9", "empty after disarmed write", buf_empty, 1);
        check(tx_done == 1'b1, "R9", "done after disarmed write", tx_done, 1);
        wait_bits(13);
        check(got_frame(n0 + 1, 10) == exp_frame(9'h066, 1'b0), "R9", "disarmed frame",
              got_frame(n0 + 1, 10), exp_frame(9'h066, 1'b0));

        // R11 / R3: back-to-back long frames with no idle gap.
        do_ctrl(1'b1, 1'b0, 1'b1);
        a = 9'h1C3;
        b = 9'h05A;
        align();
        do_read();
        n0 = log_n;
        do_data(a);
        wait_bits(3);
        align();
        do_read();
        do_data(b);
        check(buf_empty == 1'b0, "R4", "empty after second write", buf_empty, 0);
        wait_bits(25);
        check(got_frame(n0, 11) == exp_frame(a, 1'b1), "R11", "first long frame",
              got_frame(n0, 11), exp_frame(a, 1'b1));
        check(got_frame(n0 + 11, 11) == exp_frame(b, 1'b1), "R11", "chained frame",
              got_frame(n0 + 11, 11), exp_frame(b, 1'b1));
        check(empty_log[n0 + 11] == 1'b1, "R3", "empty after chained transfer",
              empty_log[n0 + 11], 1);
        check(done_log[n0 + 21] == 1'b0, "R5", "done in chained frame", done_log[n0 + 21], 0);
        check(done_log[n0 + 22] == 1'b1, "R5", "done after chain", done_log[n0 + 22], 1);

        // R10: disabled, queue data and break, then enable.
        do_ctrl(1'b0, 1'b0, 1'b0);
        do_data(9'h055);
        do_ctrl(1'b0, 1'b1, 1'b0);
        n0 = log_n;
        wait_bits(14);
        check(got_frame(n0, 12) == fill_frame(1'b1, 12), "R10", "line while disabled",
              got_frame(n0, 12), fill_frame(1'b1, 12));
        align();
        n0 = log_n;
        do_ctrl(1'b1, 1'b0, 1'b0);
        wait_bits(34);
        check(got_frame(n0, 10) == fill_frame(1'b1, 10), "R10", "preamble first",
              got_frame(n0, 10), fill_frame(1'b1, 10));
        check(got_frame(n0 + 10, 10) == fill_frame(1'b0, 10), "R10", "break second",
              got_frame(n0 + 10, 10), fill_frame(1'b0, 10));
        check(got_frame(n0 + 20, 10) == exp_frame(9'h055, 1'b0), "R10", "data last",
              got_frame(n0 + 20, 10), exp_frame(9'h055, 1'b0));

        // R2 / R4 / R9: random characters, modes and arming.
        for (int it = 0; it < 20; it++) begin
            logic [DATA_W-1:0] d;
            logic lng, armed;
            int fl;
            d     = DATA_W'($urandom);
            lng   = 1'($urandom % 2);
            armed = 1'($urandom % 2);
            fl    = frame_len(lng);
            do_ctrl(1'b1, 1'b0, lng);
            align();
            if (armed) do_read();
            else       @(negedge clk);
            n0 = log_n;
            do_data(d);
            check(buf_empty == !armed, "R4", "random empty after write", buf_empty, !armed);
            check(tx_done == !armed, "R9", "random done after write", tx_done, !armed);
            wait_bits(fl + 2);
            check(got_frame(n0, fl) == exp_frame(d, lng), "R2", "random frame",
                  got_frame(n0, fl), exp_frame(d, lng));
            check(done_log[n0 + fl - 1] == !armed, "R5", "random done in frame",
                  done_log[n0 + fl - 1], !armed);
            check(done_log[n0 + fl] == 1'b1, "R5", "random done after frame",
                  done_log[n0 + fl], 1);
        end

        finish_run();
    end

endmodule